// File: doc/BRIEF.md
# Keyed Debug Halt Control and Status Register

This block is one 32-bit register on a debugger's register bus. Through it the debugger controls a processor core: it turns debug on, requests a halt or a single step, masks interrupts and asks for snapshot stalls. The same register reports the core's run state when read. The control half is written only when the upper half-word of the write data carries a fixed unlock key. A write without the key is dropped whole, so a stray or corrupted write cannot halt the core.

On reads, the upper half-word never returns the key. It carries status instead. Register-ready, halted and sleeping are live copies of core inputs. The lockup bit is qualified by the run state. Two sticky flags record, since the last read, that the core was reset and that an instruction retired. A debugger polls the register twice: a reset flag that reads 1 then 0 marks a past reset, while 1 then 1 marks a core still held in reset. A retire flag that stays 0 marks a stalled core. A read clears a sticky flag only when no new event arrives in the same cycle.

Top module: `haltctl_reg`

## Requirements
- R1: A write (sel=1, wrEn=1) whose bits [31:16] equal 16'hA05F loads the control bits from the write data, at these positions: debug-enable at bit 0, halt at bit 1, step at bit 2, mask-interrupts at bit 3 and snap-stall at bit 5. The new values appear after the clock edge.
- R2: A write with any other value in bits [31:16], or a write with sel=0, changes no register bit.
- R3: Read data never shows the key. Bits [31:26], [23:20], [15:6] and bit 4 always read 0, whatever was written to them.
- R4: The reset-status flag, read at bit 25, sets in every cycle that coreInReset is 1. A read clears it. While the core stays in reset, back-to-back reads both return 1.
- R5: The retire-status flag, read at bit 24, sets in any cycle that coreRetired is 1. A read clears it.
- R6: If a sticky event arrives in the same cycle as the read that would clear its flag, the read returns the flag's previous value and the flag is still set afterwards.
- R7: Bit 19 reads 1 exactly when coreLockup is 1 and coreHalted is 0.
- R8: Bits 16, 17 and 18 read the current coreRegReady, coreHalted and coreSleeping inputs, in that order.
- R9: After rstN is deasserted, all control bits are 0, the reset-status flag is 1 and the retire-status flag is 0. The first read therefore returns 32'h0200_0000.
- R10: debugEn, maskInts and snapStall follow their control bits. haltReq and stepReq follow their control bits only while debug-enable is 1, and are 0 otherwise.
- R11: rdData is combinational and carries the register view only in a cycle with sel=1 and rdEn=1. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| sel | input | 1 | Address decode has selected this register |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data; the unlock key goes in [31:16] |
| rdEn | input | 1 | Read strobe; a selected read clears the sticky flags |
| rdData | output | 32 | Read data, combinational |
| coreInReset | input | 1 | Core reset is active |
| coreRetired | input | 1 | An instruction completed this cycle |
| coreHalted | input | 1 | Core is halted |
| coreSleeping | input | 1 | Core is sleeping |
| coreLockup | input | 1 | Core is in a lockup condition |
| coreRegReady | input | 1 | Core register transfer is complete |
| haltReq | output | 1 | Halt request, gated by debug-enable |
| stepReq | output | 1 | Step request, gated by debug-enable |
| debugEn | output | 1 | Debug-enable control bit |
| maskInts | output | 1 | Mask-interrupts control bit |
| snapStall | output | 1 | Snap-stall control bit |

## Verification
The assertions check on every cycle the properties that hold at every edge:
- keyed writes load the control bits, and unkeyed writes leave every output stable;
- reserved bit positions read 0, and rdData is 0 outside a selected read;
- the lockup bit and the live status bits track the core inputs;
- halt and step are gated by debug-enable;
- a read made right after a reset or retire event shows the flag set, and a read right after a read with no event shows it clear.

Only the bench's scenarios can show the values that depend on ordered history. These are the power-on state of the flags, the 1-then-1 versus 1-then-0 reset patterns over several polls, and control bits surviving a sequence of rejected writes.

// File: rtl/haltctl_pkg.sv
package haltctl_pkg;

  localparam int REG_W = 32;
  localparam int KEY_W = 16;
  localparam int KEY_LSB = REG_W - KEY_W;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;

  // control bit positions (read and write)
  localparam int POS_DBGEN = 0;
  localparam int POS_HALT  = 1;
  localparam int POS_STEP  = 2;
  localparam int POS_MASK  = 3;
  localparam int POS_SNAP  = 5;

  // status bit positions (read only)
  localparam int POS_REGRDY = 16;
  localparam int POS_HALTED = 17;
  localparam int POS_SLEEP  = 18;
  localparam int POS_LOCKUP = 19;
  localparam int POS_RETIRE = 24;
  localparam int POS_RSTSEEN = 25;

  // sticky flag indices
  localparam int NFLAG = 2;
  localparam int FLG_RETIRE = 0;
  localparam int FLG_RSTSEEN = 1;
  localparam logic [NFLAG-1:0] FLAG_RST_VAL = 2'b10;

  localparam logic [REG_W-1:0] USED_MASK =
      (REG_W'(1) << POS_DBGEN) | (REG_W'(1) << POS_HALT) | (REG_W'(1) << POS_STEP) |
      (REG_W'(1) << POS_MASK) | (REG_W'(1) << POS_SNAP) | (REG_W'(1) << POS_REGRDY) |
      (REG_W'(1) << POS_HALTED) | (REG_W'(1) << POS_SLEEP) | (REG_W'(1) << POS_LOCKUP) |
      (REG_W'(1) << POS_RETIRE) | (REG_W'(1) << POS_RSTSEEN);
  localparam logic [REG_W-1:0] RSVD_MASK = ~USED_MASK;

  typedef struct packed {
    logic snapStall;
    logic maskInts;
    logic step;
    logic halt;
    logic debugEn;
  } ctrl_t;

  typedef struct packed {
    logic ctrlLoad;  // keyed write accepted
    logic rdClear;   // selected read: clear sticky flags
    logic rdDrive;   // place view on read data
  } strobe_t;

endpackage

// File: rtl/haltctl_ctrl.sv
module haltctl_ctrl
  import haltctl_pkg::*;
(
  input  logic             sel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [KEY_W-1:0] keyField,
  output strobe_t          stb
);

  logic keyMatch;

  always_comb begin
    keyMatch     = (keyField == UNLOCK_KEY);
    stb.ctrlLoad = sel && wrEn && keyMatch;
    stb.rdClear  = sel && rdEn;
    stb.rdDrive  = sel && rdEn;
  end

endmodule

// File: rtl/haltctl_sticky.sv
module haltctl_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic setEv,
  input  logic clr,
  output logic flagQ
);

  // set has priority over clear: an event landing with a read is kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      flagQ <= RST_VAL;
    else if (setEv) flagQ <= 1'b1;
    else if (clr)   flagQ <= 1'b0;
  end

endmodule

// File: rtl/haltctl_data.sv
module haltctl_data
  import haltctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  ctrl_t            wrCtrl,
  input  logic             coreInReset,
  input  logic             coreRetired,
  input  logic             coreHalted,
  input  logic             coreSleeping,
  input  logic             coreLockup,
  input  logic             coreRegReady,
  output logic [REG_W-1:0] rdData,
  output ctrl_t            ctrlQ
);

  logic [NFLAG-1:0] flagSet;
  logic [NFLAG-1:0] flagQ;
  logic [REG_W-1:0] view;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ctrlQ <= '0;
    else if (stb.ctrlLoad) ctrlQ <= wrCtrl;
  end

  always_comb begin
    flagSet = '0;
    flagSet[FLG_RETIRE]  = coreRetired;
    flagSet[FLG_RSTSEEN] = coreInReset;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : gFlag
    haltctl_sticky #(.RST_VAL(FLAG_RST_VAL[g])) uFlag (
      .clk   (clk),
      .rstN  (rstN),
      .setEv (flagSet[g]),
      .clr   (stb.rdClear),
      .flagQ (flagQ[g])
    );
  end

  always_comb begin
    view = '0;
    view[POS_DBGEN]   = ctrlQ.debugEn;
    view[POS_HALT]    = ctrlQ.halt;
    view[POS_STEP]    = ctrlQ.step;
    view[POS_MASK]    = ctrlQ.maskInts;
    view[POS_SNAP]    = ctrlQ.snapStall;
    view[POS_REGRDY]  = coreRegReady;
    view[POS_HALTED]  = coreHalted;
    view[POS_SLEEP]   = coreSleeping;
    view[POS_LOCKUP]  = coreLockup && !coreHalted;
    view[POS_RETIRE]  = flagQ[FLG_RETIRE];
    view[POS_RSTSEEN] = flagQ[FLG_RSTSEEN];
    rdData = stb.rdDrive ? view : '0;
  end

endmodule

// File: rtl/haltctl_reg.sv
module haltctl_reg
  import haltctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdEn,
  output logic [REG_W-1:0] rdData,
  input  logic             coreInReset,
  input  logic             coreRetired,
  input  logic             coreHalted,
  input  logic             coreSleeping,
  input  logic             coreLockup,
  input  logic             coreRegReady,
  output logic             haltReq,
  output logic             stepReq,
  output logic             debugEn,
  output logic             maskInts,
  output logic             snapStall
);

  strobe_t stb;
  ctrl_t   wrCtrl;
  ctrl_t   ctrlQ;
  logic    unusedWrBits;

  always_comb begin
    wrCtrl.debugEn   = wrData[POS_DBGEN];
    wrCtrl.halt      = wrData[POS_HALT];
    wrCtrl.step      = wrData[POS_STEP];
    wrCtrl.maskInts  = wrData[POS_MASK];
    wrCtrl.snapStall = wrData[POS_SNAP];
  end

  // reserved write positions are dropped
  assign unusedWrBits = ^{wrData[KEY_LSB-1:POS_SNAP+1], wrData[POS_SNAP-1]};

  haltctl_ctrl uCtrl (
    .sel      (sel),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .keyField (wrData[REG_W-1:KEY_LSB]),
    .stb      (stb)
  );

  haltctl_data uData (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrCtrl       (wrCtrl),
    .coreInReset  (coreInReset),
    .coreRetired  (coreRetired),
    .coreHalted   (coreHalted),
    .coreSleeping (coreSleeping),
    .coreLockup   (coreLockup),
    .coreRegReady (coreRegReady),
    .rdData       (rdData),
    .ctrlQ        (ctrlQ)
  );

  always_comb begin
    debugEn   = ctrlQ.debugEn;
    maskInts  = ctrlQ.maskInts;
    snapStall = ctrlQ.snapStall;
    haltReq   = ctrlQ.halt && ctrlQ.debugEn;
    stepReq   = ctrlQ.step && ctrlQ.debugEn;
  end

endmodule

// File: rtl/haltctl_chk.sv
module haltctl_chk
  import haltctl_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             sel,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic             rdEn,
  input logic [REG_W-1:0] rdData,
  input logic             coreInReset,
  input logic             coreRetired,
  input logic             coreHalted,
  input logic             coreSleeping,
  input logic             coreLockup,
  input logic             coreRegReady,
  input logic             haltReq,
  input logic             stepReq,
  input logic             debugEn,
  input logic             maskInts,
  input logic             snapStall
);

  logic rdSel;
  logic keyOk;
  logic unusedChkBits;

  assign rdSel = sel && rdEn;
  assign keyOk = (wrData[REG_W-1:KEY_LSB] == UNLOCK_KEY);
  assign unusedChkBits = ^{wrData[KEY_LSB-1:POS_SNAP+1], wrData[POS_SNAP-1]};

  AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    sel && wrEn && keyOk |=> debugEn == $past(wrData[POS_DBGEN]) && maskInts == $past(wrData[POS_MASK])
      && snapStall == $past(wrData[POS_SNAP])
      && haltReq == ($past(wrData[POS_HALT]) && $past(wrData[POS_DBGEN]))
      && stepReq == ($past(wrData[POS_STEP]) && $past(wrData[POS_DBGEN]))); // R1

  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (!sel || !keyOk) && !(sel && wrEn && keyOk) |=> $stable(debugEn) && $stable(maskInts)
      && $stable(snapStall) && $stable(haltReq) && $stable(stepReq)); // R2

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & RSVD_MASK) == '0); // R3

  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(coreInReset) && rdSel |-> rdData[POS_RSTSEEN]); // R4

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(rdSel) && !$past(coreInReset) && rdSel |-> !rdData[POS_RSTSEEN]); // R4

  AST_RETIRE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(coreRetired) && rdSel |-> rdData[POS_RETIRE]); // R6

  AST_RETIRE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(rdSel) && !$past(coreRetired) && rdSel |-> !rdData[POS_RETIRE]); // R5

  AST_LOCKUP_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    rdSel |-> rdData[POS_LOCKUP] == (coreLockup && !coreHalted)); // R7

  AST_LIVE_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    rdSel |-> rdData[POS_REGRDY] == coreRegReady && rdData[POS_HALTED] == coreHalted
      && rdData[POS_SLEEP] == coreSleeping); // R8

  AST_GATED_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !debugEn |-> !haltReq && !stepReq); // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdSel |-> rdData == '0); // R11

endmodule

bind haltctl_reg haltctl_chk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .sel          (sel),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .rdEn         (rdEn),
  .rdData       (rdData),
  .coreInReset  (coreInReset),
  .coreRetired  (coreRetired),
  .coreHalted   (coreHalted),
  .coreSleeping (coreSleeping),
  .coreLockup   (coreLockup),
  .coreRegReady (coreRegReady),
  .haltReq      (haltReq),
  .stepReq      (stepReq),
  .debugEn      (debugEn),
  .maskInts     (maskInts),
  .snapStall    (snapStall)
);

// File: tb/haltctl_reg_test.sv
`timescale 1ns/1ps
module haltctl_reg_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        coreInReset = 1'b0;
  logic        coreRetired = 1'b0;
  logic        coreHalted = 1'b0;
  logic        coreSleeping = 1'b0;
  logic        coreLockup = 1'b0;
  logic        coreRegReady = 1'b0;
  logic        haltReq, stepReq, debugEn, maskInts, snapStall;

  int checkCount = 0;
  int failCount = 0;
  int cycleCount = 0;

  always #2.5 clk = ~clk;

  haltctl_reg uut (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .coreInReset(coreInReset), .coreRetired(coreRetired),
    .coreHalted(coreHalted), .coreSleeping(coreSleeping), .coreLockup(coreLockup),
    .coreRegReady(coreRegReady), .haltReq(haltReq), .stepReq(stepReq),
    .debugEn(debugEn), .maskInts(maskInts), .snapStall(snapStall)
  );

  // ins order: {inReset, retired, regReady, halted, sleeping, lockup}
  typedef struct packed {
    logic        doWr;
    logic        doRd;
    logic [5:0]  ins;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 6'h00, 32'hA05F_002F, 32'h0000_0000},  // R1 keyed load
    '{1'b0, 1'b1, 6'h00, 32'h0,         32'h0000_002F},  // R1
    '{1'b1, 1'b0, 6'h00, 32'h1234_0000, 32'h0000_0000},  // R2 bad key
    '{1'b0, 1'b1, 6'h00, 32'h0,         32'h0000_002F},  // R2
    '{1'b1, 1'b0, 6'h00, 32'hA05F_FFD0, 32'h0000_0000},  // R3 reserved writes
    '{1'b0, 1'b1, 6'h00, 32'h0,         32'h0000_0000},  // R3
    '{1'b0, 1'b1, 6'h0F, 32'h0,         32'h0007_0000},  // R8 live, R7 masked
    '{1'b0, 1'b1, 6'h01, 32'h0,         32'h0008_0000},  // R7 lockup running
    '{1'b1, 1'b0, 6'h10, 32'hA05F_0001, 32'h0000_0000},  // R5 retire event
    '{1'b0, 1'b1, 6'h00, 32'h0,         32'h0100_0001},  // R5
    '{1'b0, 1'b1, 6'h00, 32'h0,         32'h0000_0001},  // R5 cleared
    '{1'b0, 1'b1, 6'h10, 32'h0,         32'h0000_0001},  // R6 event with read
    '{1'b0, 1'b1, 6'h00, 32'h0,         32'h0100_0001},  // R6 kept
    '{1'b0, 1'b1, 6'h00, 32'h0,         32'h0000_0001}   // R6 cleared
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at the falling edge; combinational read data is sampled 1 ns later
  task automatic drive(input logic s, input logic w, input logic r,
                       input logic [31:0] wd, input logic [5:0] ins);
    @(negedge clk);
    sel = s; wrEn = w; rdEn = r; wrData = wd;
    {coreInReset, coreRetired, coreRegReady, coreHalted, coreSleeping, coreLockup} = ins;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 32'h0, 6'h00);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sel = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    {coreInReset, coreRetired, coreRegReady, coreHalted, coreSleeping, coreLockup} = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 5000) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog R1 cycles=%0d expected below 5000", cycleCount);
      finishRun();
    end
  end

  initial begin
    doReset();
    // R9 power-on state
    drive(1'b1, 1'b0, 1'b1, 32'h0, 6'h00);
    check("R9 first read", rdData, 32'h0200_0000);
    check("R9 outputs", {27'h0, haltReq, stepReq, debugEn, maskInts, snapStall}, 32'h0);
    drive(1'b1, 1'b0, 1'b1, 32'h0, 6'h00);
    check("R4 reset flag cleared by read", rdData, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VECS[i].doWr, VECS[i].doRd, VECS[i].wd, VECS[i].ins);
      check($sformatf("R1-table vec %0d", i), rdData, VECS[i].exp);
    end

    // R10 gating: halt+step without debug-enable
    drive(1'b1, 1'b1, 1'b0, 32'hA05F_0006, 6'h00);
    idle();
    check("R10 gated off", {29'h0, haltReq, stepReq, debugEn}, 32'h0);
    drive(1'b1, 1'b0, 1'b1, 32'h0, 6'h00);
    check("R1 bits stored while gated", rdData, 32'h0000_0006);
    drive(1'b1, 1'b1, 1'b0, 32'hA05F_0007, 6'h00);
    idle();
    check("R10 enabled", {27'h0, haltReq, stepReq, debugEn, maskInts, snapStall}, 32'h0000_001C);
    drive(1'b1, 1'b1, 1'b0, 32'hA05F_0028, 6'h00);
    idle();
    check("R10 mask/snap", {27'h0, haltReq, stepReq, debugEn, maskInts, snapStall}, 32'h0000_0003);

    // R2 unselected keyed write ignored
    drive(1'b0, 1'b1, 1'b0, 32'hA05F_0007, 6'h00);
    drive(1'b1, 1'b0, 1'b1, 32'h0, 6'h00);
    check("R2 unselected write", rdData, 32'h0000_0028);

    // R11 read data zero without a selected read
    drive(1'b1, 1'b0, 1'b0, 32'h0, 6'h0F);
    check("R11 sel without rdEn", rdData, 32'h0);
    drive(1'b0, 1'b0, 1'b1, 32'h0, 6'h0F);
    check("R11 rdEn without sel", rdData, 32'h0);

    // R4 core held in reset: 1 then 1, then release: 1 then 0
    drive(1'b0, 1'b0, 1'b0, 32'h0, 6'h20);
    drive(1'b1, 1'b0, 1'b1, 32'h0, 6'h20);
    check("R4 held read 1", rdData, 32'h0200_0028);
    drive(1'b1, 1'b0, 1'b1, 32'h0, 6'h20);
    check("R4 held read 2", rdData, 32'h0200_0028);
    drive(1'b1, 1'b0, 1'b1, 32'h0, 6'h00);
    check("R4 released read", rdData, 32'h0200_0028);
    drive(1'b1, 1'b0, 1'b1, 32'h0, 6'h00);
    check("R4 past reset cleared", rdData, 32'h0000_0028);

    // R9 reset again mid-run
    doReset();
    drive(1'b1, 1'b0, 1'b1, 32'h0, 6'h00);
    check("R9 re-reset read", rdData, 32'h0200_0000);
    check("R9 re-reset outputs", {27'h0, haltReq, stepReq, debugEn, maskInts, snapStall}, 32'h0);
    idle();

    finishRun();
  end

endmodule